// File: doc/BRIEF.md
# Internal Bus Wait-State Generator

This block sits between a CPU bus master and the on-chip memory regions and decides how many bus clock cycles each access lasts. It decodes the access address into one of four on-chip regions: special-function registers, internal RAM, program ROM and data flash. It then picks a cycle count for that region from three software wait-control bits and a PLL-enable input. It signals the end of the access with a single-cycle ready pulse.

The wait-control bits are held in a small configuration register with a write strobe and a readback path. An address that falls outside the four regions is reported on a one-cycle miss flag, and no access is started for it. The cycle count is fixed when the access is accepted, so software may rewrite the configuration at any time.

Top module: `bus_wait_gen`

## Requirements
- R1: The address map is as follows. SFR is 0x00000–0x003FF. RAM is 0x00400–0x07FFF. Data flash is 0x0E000–0x0FFFF. Program ROM is 0x80000–0xFFFFF. Every other address is external.
- R2: With `pll_on`=1, an SFR access lasts 2 cycles when config bit 0 (SFR fast select) is 1 and 3 cycles when it is 0. Config bits 1 and 2 have no effect on SFR accesses.
- R3: With `pll_on`=0, an SFR access always lasts 3 cycles, whatever the value of bit 0.
- R4: RAM and program ROM accesses last 1 cycle when config bit 1 (global wait) is 0 and 2 cycles when it is 1. Bit 0, bit 2 and `pll_on` have no effect on them.
- R5: A data flash access lasts 2 cycles whenever config bit 2 (flash fast enable) is 0.
- R6: With config bit 2 at 1, a data flash access lasts 1 cycle when bit 1 is 0 and 2 cycles when bit 1 is 1.
- R7: After reset, `cfg_rdata` reads 3'b001. A write with `cfg_we` high stores `cfg_wdata`, and the new value is visible on `cfg_rdata` after that clock edge.
- R8: An access is accepted on a rising edge where `req` is high and `busy` is low. For an N-cycle access, `ready` is high for exactly one cycle: the cycle that follows the (N-1)-th edge after the accepting edge. `busy` is high from the accepting edge up to and including the ready cycle. A `req` that arrives while `busy` is high is ignored.
- R9: The cycle count is taken from the configuration at the accepting edge. A configuration write during an access changes only later accesses.
- R10: A request to an external address starts no access: `busy` stays low and `ext_miss` is high for one cycle after the edge.

Cycle numbering used above: the accepting edge counts as edge 0, so for a 1-cycle access (N=1) `ready` is high in the cycle right after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request |
| addr | input | ADDR_W | Access address |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 3 | Configuration write data: bit 2 flash fast, bit 1 global wait, bit 0 SFR fast |
| pll_on | input | 1 | PLL enabled flag |
| cfg_rdata | output | 3 | Configuration readback |
| busy | output | 1 | Access in progress |
| ready | output | 1 | Final cycle of the access |
| ext_miss | output | 1 | Request hit an external address |

## Verification
The bench builds the block with its default parameters: a 20-bit address and the region bounds given in R1. With these values it can reach both edges of each region and the gaps between regions. It can also reach every combination of the three wait bits and the PLL flag that changes a cycle count, and the one-, two- and three-cycle access lengths.

// File: rtl/bus_wait_gen.sv
module bus_wait_gen #(
  parameter int ADDR_W = 20,
  parameter logic [ADDR_W-1:0] SFR_HI = 20'h003FF,
  parameter logic [ADDR_W-1:0] RAM_LO = 20'h00400,
  parameter logic [ADDR_W-1:0] RAM_HI = 20'h07FFF,
  parameter logic [ADDR_W-1:0] DF_LO  = 20'h0E000,
  parameter logic [ADDR_W-1:0] DF_HI  = 20'h0FFFF,
  parameter logic [ADDR_W-1:0] ROM_LO = 20'h80000,
  parameter logic [2:0] CFG_RST = 3'b001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_wdata,
  input  logic              pll_on,
  output logic [2:0]        cfg_rdata,
  output logic              busy,
  output logic              ready,
  output logic              ext_miss
);
  localparam int CNT_W = 2;

  logic [2:0] cfg;
  logic [CNT_W-1:0] cnt, len;
  logic is_sfr, is_ram, is_df, is_rom, is_ext, accept;

  wire sfr_fast = cfg[0];
  wire gwait    = cfg[1];
  wire df_fast  = cfg[2];

  assign is_sfr = addr <= SFR_HI;
  assign is_ram = addr >= RAM_LO && addr <= RAM_HI;
  assign is_df  = addr >= DF_LO && addr <= DF_HI;
  assign is_rom = addr >= ROM_LO;
  assign is_ext = !(is_sfr || is_ram || is_df || is_rom);
  assign accept = req && !busy;

  always_comb begin
    if (is_sfr)      len = (pll_on && sfr_fast) ? 2'd2 : 2'd3;
    else if (is_df)  len = (!df_fast || gwait) ? 2'd2 : 2'd1;
    else             len = gwait ? 2'd2 : 2'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg <= CFG_RST;
    else if (cfg_we) cfg <= cfg_wdata;
  end
  assign cfg_rdata = cfg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ready <= 1'b0;
      cnt <= '0;
      ext_miss <= 1'b0;
    end else begin
      ext_miss <= accept && is_ext;
      if (busy) begin
        if (ready) begin
          busy <= 1'b0;
          ready <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
          ready <= (cnt == 2'd1);
        end
      end else if (accept && !is_ext) begin
        busy <= 1'b1;
        cnt <= len - 1'b1;
        ready <= (len == 2'd1);
      end
    end
  end

  assert_ready_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);
  assert_ready_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> busy);
  assert_ext_no_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_ext) |=> (!busy && ext_miss));
  assert_sfr_slow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_sfr && !pll_on) |=> (busy && !ready));
  assert_ram_fast_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (is_ram || is_rom) && !cfg[1]) |=> ready);
  assert_df_slow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_df && !cfg[2]) |=> (busy && !ready));
  assert_cfg_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == $past(cfg_wdata));
endmodule

// File: tb/test_bus_wait_gen.sv
module test_bus_wait_gen;
  localparam int CLK_P = 10;
  localparam int NV = 17;
  // {cfg[2:0], pll, addr[19:0], expected cycles (0 = external)}
  localparam logic [27:0] VEC [NV] = '{
    {3'b001, 1'b1, 20'h00010, 4'd2},
    {3'b000, 1'b1, 20'h003FF, 4'd3},
    {3'b001, 1'b0, 20'h00100, 4'd3},
    {3'b111, 1'b1, 20'h00200, 4'd2},
    {3'b110, 1'b1, 20'h00000, 4'd3},
    {3'b000, 1'b1, 20'h00400, 4'd1},
    {3'b010, 1'b1, 20'h07FFF, 4'd2},
    {3'b101, 1'b0, 20'h01000, 4'd1},
    {3'b000, 1'b1, 20'h80000, 4'd1},
    {3'b010, 1'b0, 20'hFFFFF, 4'd2},
    {3'b000, 1'b1, 20'h0E000, 4'd2},
    {3'b010, 1'b1, 20'h0FFFF, 4'd2},
    {3'b100, 1'b1, 20'h0E800, 4'd1},
    {3'b110, 1'b1, 20'h0F000, 4'd2},
    {3'b000, 1'b1, 20'h08000, 4'd0},
    {3'b000, 1'b1, 20'h7FFFF, 4'd0},
    {3'b000, 1'b1, 20'h0DFFF, 4'd0}
  };

  logic clk = 0, rst_n = 0, req = 0, cfg_we = 0, pll_on = 1;
  logic [19:0] addr = '0;
  logic [2:0] cfg_wdata = '0, cfg_rdata;
  logic busy, ready, ext_miss;
  int checks = 0, fails = 0, n;
  bit done = 0;

  bus_wait_gen i_bus_wait_gen (.clk(clk), .rst_n(rst_n), .req(req), .addr(addr),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .pll_on(pll_on), .cfg_rdata(cfg_rdata),
    .busy(busy), .ready(ready), .ext_miss(ext_miss));

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [2:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic access(input logic [19:0] a, input int exp, input string tag);
    @(negedge clk); req = 1; addr = a;
    @(negedge clk); req = 0;
    if (exp == 0) begin
      check({tag, " R10 ext_miss"}, ext_miss, 1);
      check({tag, " R10 busy"}, busy, 0);
    end else begin
      n = 1;
      while (!ready && n < 8) begin @(negedge clk); n++; end
      check({tag, " cycles"}, n, exp);
      @(negedge clk);
      check({tag, " R8 ready width"}, ready, 0);
    end
  endtask

  initial begin
    #(CLK_P * 5000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R7 reset cfg", cfg_rdata, 3'b001);
    check("R8 reset busy", busy, 0);
    check("R8 reset ready", ready, 0);
    // default config: SFR 2, RAM 1, flash 2 (R7)
    access(20'h00020, 2, "R7 default SFR");
    access(20'h00500, 1, "R7 default RAM");
    access(20'h0E100, 2, "R7 default flash");

    for (int i = 0; i < NV; i++) begin
      write_cfg(VEC[i][27:25]);
      check("R7 readback", cfg_rdata, VEC[i][27:25]);
      pll_on = VEC[i][24];
      access(VEC[i][23:4], int'(VEC[i][3:0]),
             $sformatf("R1 R2 R3 R4 R5 R6 vector %0d", i));
    end
    pll_on = 1;

    // R8: request held high during a 3-cycle access is ignored
    write_cfg(3'b000);
    @(negedge clk); req = 1; addr = 20'h00010;
    @(negedge clk); addr = 20'h00400;
    check("R8 cycle1 ready", ready, 0);
    @(negedge clk); check("R8 cycle2 ready", ready, 0);
    @(negedge clk); check("R8 cycle3 ready", ready, 1);
    @(negedge clk);
    check("R8 after ready", ready, 0);
    check("R8 idle after ready", busy, 0);
    @(negedge clk); req = 0;
    check("R8 next access accepted", ready, 1);
    @(negedge clk);

    // R9: config write during an access affects only later ones
    write_cfg(3'b001);
    @(negedge clk); req = 1; addr = 20'h00010;
    @(negedge clk); req = 0; cfg_we = 1; cfg_wdata = 3'b000;
    check("R9 cycle1", ready, 0);
    @(negedge clk); cfg_we = 0;
    check("R9 old count used", ready, 1);
    access(20'h00010, 3, "R9 new count used");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule